// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port Controller

This block controls a parameterised bank of general-purpose pins, eight wide by default. Software reaches it through a small synchronous register port. It can program a data value, and for each pin an output enable, an open-drain mode, an interrupt enable and an interrupt edge polarity. Each pin gets a pad drive pair: a drive enable and an output level. Open-drain pins drive only low and float otherwise. A read of the data address returns the live pin levels after a synchroniser, not the last value written.

Every pin can flag a rising or a falling transition. These per-pin events merge into a single port interrupt request. This request is a sticky pending flag that software clears through a status register. Because the sources share one request, an arming flag gates new interrupts: once the port has fired, no further event is accepted until every enabled source has gone back to its inactive level. Edge detection looks at the pin level itself, so a pin that the port drives as an output can trigger its own interrupt.

Top module: `gpio_port_ctrl`

## Requirements
- R1: In normal (non-open-drain) mode, `pad_drive` equals the output-enable register and `pad_out` equals the data register on driven pins. A pin whose output enable is 0 is never driven.
- R2: For a pin with open-drain set and output enable set, data 1 gives `pad_drive`=0 (high impedance), and data 0 gives `pad_drive`=1 with `pad_out`=0. An open-drain pin is never driven high.
- R3: A read of address 0 returns the pin levels taken through a two-flop synchroniser, not the written data value.
- R4: After reset, data, output enable, open-drain, interrupt enable and edge select are all 0. The status register reads 0x02 (armed set, pending clear) and `port_irq` is low.
- R5: With edge select bit 0 (rising) or 1 (falling) at address 4, an enabled pin that makes the selected transition while the port is armed sets pending, and `port_irq` goes high.
- R6: A pin whose interrupt-enable bit (address 3) is 0 never sets pending.
- R7: Once an interrupt is taken, armed (status bit 1) stays clear and no event sets pending until every enabled pin sits at its inactive level. The inactive level is low for rising-select pins and high for falling-select pins. Armed then returns to 1.
- R8: A pin configured as an output raises an interrupt when the level the port drives on it makes the selected transition.
- R9: Pending (status bit 0, address 5) stays set until a write to address 5 with bit 0 = 1. `port_irq` follows pending.
- R10: Writing the edge-select or interrupt-enable register creates no event while the pin levels are unchanged.
- R11: Addresses 1 (output enable), 2 (open-drain), 3 (interrupt enable) and 4 (edge select) read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data for `reg_addr` |
| pad_in | input | WIDTH | Raw pin levels from the pads |
| pad_out | output | WIDTH | Level driven on each pin |
| pad_drive | output | WIDTH | Per-pin drive enable (0 = high impedance) |
| port_irq | output | 1 | Shared port interrupt request |

## Verification
On every cycle the assertions check that drive is confined to output-enabled pins and that open-drain pins never drive high. They also check that pending rises only when the port was armed and at least one pin was enabled, and that pending never drops without a clear. Whether the right edge polarity fires is something only the bench scenarios can show. The same holds for the synchronised read-back levels, the re-arm point after the shared sources settle, a driven output firing its own interrupt, and the absence of events after edge-select or enable writes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_DATA = 3'd0,
      REG_OE   = 3'd1,
      REG_OD   = 3'd2,
      REG_IEN  = 3'd3,
      REG_EDGE = 3'd4,
      REG_STAT = 3'd5
   } reg_sel_e;

   localparam int STAT_PEND_BIT = 0;
   localparam int STAT_ARM_BIT  = 1;
   localparam int STAT_BITS     = 2;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_edge.sv
module gpio_port_edge #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] smp,
   input  logic [WIDTH-1:0] ien,
   input  logic [WIDTH-1:0] fall_sel,
   output logic [WIDTH-1:0] evt,
   output logic [WIDTH-1:0] act
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= smp;
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic rise_w, fall_w;
      assign rise_w = smp[b] & ~prev_q[b];
      assign fall_w = ~smp[b] & prev_q[b];
      assign evt[b] = ien[b] & (fall_sel[b] ? fall_w : rise_w);
      assign act[b] = ien[b] & (fall_sel[b] ? ~smp[b] : smp[b]);
   end
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt,
   input  logic [WIDTH-1:0] act,
   input  logic             clr_pend,
   output logic             pending,
   output logic             armed
);
   logic any_evt, any_act, take;

   assign any_evt = |evt;
   assign any_act = |act;
   assign take    = armed & any_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b1;
         pending <= 1'b0;
      end else begin
         if (take)                   armed <= 1'b0;
         else if (!armed && !any_act) armed <= 1'b1;

         if (take)          pending <= 1'b1;
         else if (clr_pend) pending <= 1'b0;
      end
   end
endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad #(
   parameter int WIDTH      = 8,
   parameter bit OD_SUPPORT = 1'b1
) (
   input  logic [WIDTH-1:0] data,
   input  logic [WIDTH-1:0] oe,
   input  logic [WIDTH-1:0] od,
   output logic [WIDTH-1:0] out,
   output logic [WIDTH-1:0] drive
);
   if (OD_SUPPORT) begin : g_od
      assign drive = oe & ~(od & data);
      assign out   = data & ~od;
   end else begin : g_push_pull
      logic unused_od;
      assign unused_od = ^od;
      assign drive     = oe;
      assign out       = data;
   end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int BUS_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit OD_SUPPORT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_drive,
   output logic              port_irq
);
   if (WIDTH < 1 || WIDTH > BUS_W) begin : g_bad_width
      $error("gpio_port_ctrl: WIDTH must be between 1 and BUS_W");
   end
   if (BUS_W < STAT_BITS) begin : g_bad_bus
      $error("gpio_port_ctrl: BUS_W too narrow for the status register");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] data_q, oe_q, od_q, ien_q, edge_q;
   logic [WIDTH-1:0] smp, evt, act;
   logic             pending, armed, clr_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         oe_q   <= '0;
         od_q   <= '0;
         ien_q  <= '0;
         edge_q <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            REG_DATA: data_q <= reg_wdata[WIDTH-1:0];
            REG_OE:   oe_q   <= reg_wdata[WIDTH-1:0];
            REG_OD:   od_q   <= reg_wdata[WIDTH-1:0];
            REG_IEN:  ien_q  <= reg_wdata[WIDTH-1:0];
            REG_EDGE: edge_q <= reg_wdata[WIDTH-1:0];
            default: ;
         endcase
      end
   end

   assign clr_pend = reg_wr && (reg_addr == REG_STAT) && reg_wdata[STAT_PEND_BIT];

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_DATA: reg_rdata[WIDTH-1:0] = smp;
         REG_OE:   reg_rdata[WIDTH-1:0] = oe_q;
         REG_OD:   reg_rdata[WIDTH-1:0] = od_q;
         REG_IEN:  reg_rdata[WIDTH-1:0] = ien_q;
         REG_EDGE: reg_rdata[WIDTH-1:0] = edge_q;
         REG_STAT: begin
            reg_rdata[STAT_PEND_BIT] = pending;
            reg_rdata[STAT_ARM_BIT]  = armed;
         end
         default: ;
      endcase
   end

   gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(smp)
   );

   gpio_port_edge #(.WIDTH(WIDTH)) i_edge (
      .clk(clk), .rst_n(rst_n), .smp(smp), .ien(ien_q), .fall_sel(edge_q),
      .evt(evt), .act(act)
   );

   gpio_port_irq #(.WIDTH(WIDTH)) i_irq (
      .clk(clk), .rst_n(rst_n), .evt(evt), .act(act), .clr_pend(clr_pend),
      .pending(pending), .armed(armed)
   );

   gpio_port_pad #(.WIDTH(WIDTH), .OD_SUPPORT(OD_SUPPORT)) i_pad (
      .data(data_q), .oe(oe_q), .od(od_q), .out(pad_out), .drive(pad_drive)
   );

   assign port_irq = pending;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int WIDTH      = 8,
   parameter bit OD_SUPPORT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] pad_drive,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] oe_q,
   input logic [WIDTH-1:0] od_q,
   input logic [WIDTH-1:0] ien_q,
   input logic             pending,
   input logic             armed,
   input logic             clr_pend
);
   // R1: only output-enabled pins are ever driven
   p_drive_in_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_drive & ~oe_q) == '0);

   // R2: an open-drain pin never drives a high level
   p_od_never_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !OD_SUPPORT || ((od_q & pad_drive & pad_out) == '0));

   // R6: pending can only rise when some pin was enabled
   p_pend_needs_ien_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> $past(|ien_q));

   // R7: pending can only rise from the armed state
   p_pend_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> $past(armed));

   // R9: pending holds until an explicit clear
   p_pend_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !clr_pend) |=> pending);
endmodule

bind gpio_port_ctrl gpio_port_chk #(.WIDTH(WIDTH), .OD_SUPPORT(OD_SUPPORT)) i_gpio_port_chk (
   .clk(clk), .rst_n(rst_n), .pad_drive(pad_drive), .pad_out(pad_out),
   .oe_q(oe_q), .od_q(od_q), .ien_q(ien_q), .pending(pending),
   .armed(armed), .clr_pend(clr_pend)
);

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [7:0] pad_in, pad_out, pad_drive;
   logic       port_irq;
   logic [7:0] ext_lvl = 8'h00;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // model state
   logic [7:0] m_data = 0, m_oe = 0, m_od = 0, m_ien = 0, m_edge = 0, m_prev = 0;
   logic       m_pend = 0, m_arm = 1;

   always #4 clk = ~clk;

   assign pad_in = (pad_drive & pad_out) | (~pad_drive & ext_lvl);

   gpio_port_ctrl i_gpio_port_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_drive(pad_drive), .port_irq(port_irq)
   );

   function automatic logic [7:0] exp_drive(logic [7:0] oe, logic [7:0] od, logic [7:0] d);
      return oe & ~(od & d);
   endfunction

   function automatic logic [7:0] exp_out(logic [7:0] od, logic [7:0] d);
      return d & ~od;
   endfunction

   function automatic logic [7:0] exp_pins(logic [7:0] oe, logic [7:0] od, logic [7:0] d, logic [7:0] e);
      logic [7:0] dr;
      dr = exp_drive(oe, od, d);
      return (dr & exp_out(od, d)) | (~dr & e);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic step();
      logic [7:0] np, ev, act, v, dr;
      np = exp_pins(m_oe, m_od, m_data, ext_lvl);
      ev = m_ien & ((m_edge & m_prev & ~np) | (~m_edge & ~m_prev & np));
      if (m_arm && (ev != 0)) begin
         m_pend = 1'b1;
         m_arm  = 1'b0;
      end
      m_prev = np;
      repeat (4) @(negedge clk);
      act = m_ien & ((m_edge & ~np) | (~m_edge & np));
      if (!m_arm && act == 0) m_arm = 1'b1;
      dr = exp_drive(m_oe, m_od, m_data);
      check("R1/R2 pad_drive", pad_drive, dr);
      check("R1/R2 pad_out", pad_out & pad_drive, exp_out(m_od, m_data) & dr);
      rd(3'd0, v);
      check("R3 pin readback", v, np);
      rd(3'd5, v);
      check("R7/R9 status", v, {6'd0, m_arm, m_pend});
      check("R5/R9 port_irq", port_irq, m_pend);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wr    = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      case (a)
         3'd0: m_data = d;
         3'd1: m_oe   = d;
         3'd2: m_od   = d;
         3'd3: m_ien  = d;
         3'd4: m_edge = d;
         3'd5: if (d[0]) m_pend = 1'b0;
         default: ;
      endcase
      step();
   endtask

   task automatic set_ext(input logic [7:0] e);
      @(negedge clk);
      ext_lvl = e;
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R4 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'h0000_5eed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: reset state
      for (int a = 0; a < 5; a++) begin
         rd(a[2:0], v);
         check("R4 reset register", v, 8'h00);
      end
      rd(3'd5, v);
      check("R4 reset status", v, 8'h02);
      check("R4 reset irq", port_irq, 1'b0);
      check("R4 reset drive", pad_drive, 8'h00);

      // R3: read returns pins, not the written value
      wr(3'd0, 8'hFF);
      set_ext(8'h5A);
      rd(3'd0, v);
      check("R3 read is pin level", v, 8'h5A);

      // R6: disabled pins never interrupt
      set_ext(8'hA5);
      check("R6 disabled no irq", port_irq, 1'b0);

      // R5: rising edge on an enabled pin
      wr(3'd4, 8'h00);
      wr(3'd3, 8'h03);
      set_ext(8'hA4);
      check("R5 falling ignored on rising select", port_irq, 1'b0);
      set_ext(8'hA5);
      check("R5 rising edge irq", port_irq, 1'b1);
      repeat (10) @(negedge clk);
      check("R9 pending sticky", port_irq, 1'b1);
      wr(3'd5, 8'h01);
      check("R9 cleared", port_irq, 1'b0);

      // R7: re-arm gating
      set_ext(8'hA7);
      check("R7 no irq while source active", port_irq, 1'b0);
      set_ext(8'hA6);
      rd(3'd5, v);
      check("R7 still disarmed", v, 8'h00);
      set_ext(8'hA4);
      rd(3'd5, v);
      check("R7 rearmed", v, 8'h02);
      set_ext(8'hA6);
      check("R7 irq after rearm", port_irq, 1'b1);
      wr(3'd5, 8'h01);

      // R10: edge select change creates no event; R5 falling
      wr(3'd4, 8'h03);
      check("R10 no event on edge write", port_irq, 1'b0);
      set_ext(8'hA7);
      check("R5 rising ignored on falling select", port_irq, 1'b0);
      set_ext(8'hA5);
      check("R5 falling edge irq", port_irq, 1'b1);
      wr(3'd5, 8'h01);
      wr(3'd3, 8'h00);
      wr(3'd4, 8'h00);
      wr(3'd3, 8'hA5);
      check("R10 no event on enable write", port_irq, 1'b0);
      wr(3'd3, 8'h00);

      // R8: driven output triggers its own interrupt
      wr(3'd0, 8'h00);
      wr(3'd3, 8'h10);
      wr(3'd1, 8'h10);
      check("R8 no irq yet", port_irq, 1'b0);
      wr(3'd0, 8'h10);
      check("R8 output drives irq", port_irq, 1'b1);
      wr(3'd5, 8'h01);

      // R2: open drain
      wr(3'd2, 8'h10);
      check("R2 od one floats", pad_drive, 8'h00);
      wr(3'd0, 8'h00);
      check("R2 od zero drives", pad_drive, 8'h10);
      check("R2 od zero low", pad_out & 8'h10, 8'h00);

      // random mix
      for (int i = 0; i < 400; i++) begin
         int op;
         logic [7:0] r;
         op = $urandom % 8;
         r  = 8'($urandom);
         case (op)
            0: set_ext(r);
            1: wr(3'd0, r);
            2: wr(3'd1, r);
            3: wr(3'd2, r);
            4: wr(3'd3, r);
            5: wr(3'd4, r);
            6: wr(3'd5, {7'd0, r[0]});
            default: begin
               logic [2:0] a;
               a = 3'(1 + ($urandom % 4));
               rd(a, v);
               case (a)
                  3'd1: check("R11 oe readback", v, m_oe);
                  3'd2: check("R11 od readback", v, m_od);
                  3'd3: check("R11 ien readback", v, m_ien);
                  default: check("R11 edge readback", v, m_edge);
               endcase
            end
         endcase
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule